// File: doc/BRIEF.md
# Atomic Memory Read-Modify-Write Unit

This block carries out the nine word-sized atomic memory operations of a 32-bit RISC core: swap, add, and, or, xor, signed minimum, signed maximum, unsigned minimum and unsigned maximum. The pipeline presents an instruction word with its two register operands. The unit latches the operation, the address taken from the first source register and the operand from the second. It then reads the addressed word from a single-ported data memory and writes back the combined value. When the write has been acknowledged, it returns the word that was in memory before the write so that it can be placed in the destination register.

The memory side is a plain request/ready port with a separate read-response strobe. A request is held steady until ready is seen. Read data arrives on a later cycle. Instructions with an unknown operation code or a wrong width field, and addresses that are not word aligned, are rejected with a one-cycle flag. A rejected instruction touches neither memory nor the register file.

Top module: `amo_rmw_unit`

## Requirements
- R1: An instruction is taken when `start_i` is high, the unit is idle, instr[6:0] equals 0101111 and instr[14:12] equals 010. A start with any other opcode leaves busy, the flags, memory and the register write port untouched.
- R2: The operation comes from instr[31:27]: 00001 swap (the new word is rs2), 00000 add (modulo 2^32), 01100 and, 01000 or, 00100 xor.
- R3: 10000 and 10100 write the smaller or larger value compared as two's-complement signed. 11000 and 11100 write the smaller or larger value compared as unsigned.
- R4: The unit first issues one read request (`mem_we_o`=0) at the address rs1. After the read response it issues one write request (`mem_we_o`=1) at the same address, with `mem_be_o`=1111 and the computed word.
- R5: `rd_we_o` pulses exactly once per accepted operation, in the cycle after the write request is acknowledged. `rd_data_o` then carries the old memory word and `rd_idx_o` carries instr[11:7].
- R6: `busy_o` is high from the cycle after acceptance through the cycle of the write acknowledge. A memory request and its address, write enable and data stay unchanged until `mem_ready_i` is seen.
- R7: With opcode and width matching but a funct5 outside the nine codes, or with the opcode matching and the width field not 010, `illegal_o` pulses for one cycle right after the start. Memory and rd stay untouched and busy stays low.
- R8: A legal operation whose rs1[1:0] is not 00 pulses `misalign_o` for one cycle right after the start, without any memory request or rd write. An illegal instruction reports only `illegal_o`.
- R9: Instruction bits 26:25 (the ordering hints) have no effect on the result, the timing or the memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Instruction presented this cycle |
| instr_i | input | 32 | Instruction word |
| rs1_i | input | 32 | First source operand (address) |
| rs2_i | input | 32 | Second source operand |
| busy_o | output | 1 | Operation in progress |
| illegal_o | output | 1 | Unsupported encoding pulse |
| misalign_o | output | 1 | Unaligned address pulse |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte lane enables |
| mem_ready_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| rd_we_o | output | 1 | Destination register write pulse |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | 32 | Old memory word for rd |

## Verification
A start sampled at a clock edge raises `busy_o`, or one of the two reject flags, in the cycle right after that edge. The bench checks these on the next falling edge, and checks one cycle later that the flags have dropped. The write into the bench memory and the `rd_we_o` pulse both appear in the cycle after the write acknowledge edge. The bench therefore waits, falling edge by falling edge, for the first `rd_we_o` and compares rd, memory contents and busy in that same cycle. It confirms the single pulse one cycle later. The memory model delays ready by a pseudo-random pattern and returns read data one cycle after the read handshake, so every sweep runs under varying wait states.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int XLEN = 32;
    localparam int BE_W = XLEN / 8;

    localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
    localparam logic [2:0] WIDTH_WORD = 3'b010;

    typedef enum logic [4:0] {
        OP_ADD  = 5'b00000,
        OP_SWAP = 5'b00001,
        OP_XOR  = 5'b00100,
        OP_OR   = 5'b01000,
        OP_AND  = 5'b01100,
        OP_MIN  = 5'b10000,
        OP_MAX  = 5'b10100,
        OP_MINU = 5'b11000,
        OP_MAXU = 5'b11100
    } amo_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_WAIT,
        SQ_STORE
    } seq_state_e;

    typedef struct packed {
        logic    is_amo;
        logic    legal;
        amo_op_e op;
        logic [4:0] rd;
    } amo_dec_t;

    function automatic logic op_supported(input logic [4:0] f5);
        case (f5)
            OP_ADD, OP_SWAP, OP_XOR, OP_OR, OP_AND,
            OP_MIN, OP_MAX, OP_MINU, OP_MAXU: op_supported = 1'b1;
            default:                          op_supported = 1'b0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] amo_combine(
        input amo_op_e         op,
        input logic [XLEN-1:0] cur,
        input logic [XLEN-1:0] arg
    );
        logic s_lt;
        logic u_lt;
        s_lt = $signed(arg) < $signed(cur);
        u_lt = arg < cur;
        case (op)
            OP_SWAP: amo_combine = arg;
            OP_ADD:  amo_combine = cur + arg;
            OP_XOR:  amo_combine = cur ^ arg;
            OP_OR:   amo_combine = cur | arg;
            OP_AND:  amo_combine = cur & arg;
            OP_MIN:  amo_combine = s_lt ? arg : cur;
            OP_MAX:  amo_combine = s_lt ? cur : arg;
            OP_MINU: amo_combine = u_lt ? arg : cur;
            OP_MAXU: amo_combine = u_lt ? cur : arg;
            default: amo_combine = cur;
        endcase
    endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output amo_dec_t        dec_o
);
    logic [4:0] f5;
    assign f5 = instr_i[31:27];

    always_comb begin
        dec_o.is_amo = (instr_i[6:0] == OPC_ATOMIC);
        dec_o.legal  = (instr_i[14:12] == WIDTH_WORD) && op_supported(f5);
        dec_o.op     = amo_op_e'(f5);
        dec_o.rd     = instr_i[11:7];
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
(
    input  amo_op_e         op_i,
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] opnd_i,
    output logic [XLEN-1:0] new_o
);
    assign new_o = amo_combine(op_i, old_i, opnd_i);
endmodule

// File: rtl/amo_seq.sv
module amo_seq
    import amo_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  amo_dec_t          dec_i,
    input  logic [XLEN-1:0]   rs1_i,
    input  logic [XLEN-1:0]   rs2_i,
    input  logic [XLEN-1:0]   new_i,
    output amo_op_e           op_o,
    output logic [XLEN-1:0]   old_o,
    output logic [XLEN-1:0]   opnd_o,
    output logic              busy_o,
    output logic              illegal_o,
    output logic              misalign_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [XLEN-1:0]   mem_wdata_o,
    output logic [BE_W-1:0]   mem_be_o,
    input  logic              mem_ready_i,
    input  logic              mem_rvalid_i,
    input  logic [XLEN-1:0]   mem_rdata_i,
    output logic              rd_we_o,
    output logic [4:0]        rd_idx_o
);
    seq_state_e        st_q;
    amo_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [XLEN-1:0]   opnd_q;
    logic [XLEN-1:0]   old_q;
    logic [4:0]        rd_q;
    logic              ill_q;
    logic              mis_q;
    logic              wb_q;
    logic              take;

    assign take = start_i && (st_q == SQ_IDLE) && dec_i.is_amo;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            op_q   <= OP_ADD;
            addr_q <= '0;
            opnd_q <= '0;
            old_q  <= '0;
            rd_q   <= '0;
            ill_q  <= 1'b0;
            mis_q  <= 1'b0;
            wb_q   <= 1'b0;
        end else begin
            ill_q <= 1'b0;
            mis_q <= 1'b0;
            wb_q  <= 1'b0;
            case (st_q)
                SQ_IDLE: begin
                    if (take) begin
                        if (!dec_i.legal) begin
                            ill_q <= 1'b1;
                        end else if (rs1_i[1:0] != 2'b00) begin
                            mis_q <= 1'b1;
                        end else begin
                            op_q   <= dec_i.op;
                            addr_q <= rs1_i[ADDR_W-1:0];
                            opnd_q <= rs2_i;
                            rd_q   <= dec_i.rd;
                            st_q   <= SQ_LOAD;
                        end
                    end
                end
                SQ_LOAD: if (mem_ready_i) st_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (mem_rvalid_i) begin
                        old_q <= mem_rdata_i;
                        st_q  <= SQ_STORE;
                    end
                end
                SQ_STORE: begin
                    if (mem_ready_i) begin
                        wb_q <= 1'b1;
                        st_q <= SQ_IDLE;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign op_o        = op_q;
    assign old_o       = old_q;
    assign opnd_o      = opnd_q;
    assign busy_o      = (st_q != SQ_IDLE);
    assign illegal_o   = ill_q;
    assign misalign_o  = mis_q;
    assign mem_req_o   = (st_q == SQ_LOAD) || (st_q == SQ_STORE);
    assign mem_we_o    = (st_q == SQ_STORE);
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = new_i;
    assign mem_be_o    = '1;
    assign rd_we_o     = wb_q;
    assign rd_idx_o    = rd_q;
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [31:0]       instr_i,
    input  logic [31:0]       rs1_i,
    input  logic [31:0]       rs2_i,
    output logic              busy_o,
    output logic              illegal_o,
    output logic              misalign_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    output logic [3:0]        mem_be_o,
    input  logic              mem_ready_i,
    input  logic              mem_rvalid_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              rd_we_o,
    output logic [4:0]        rd_idx_o,
    output logic [31:0]       rd_data_o
);
    amo_dec_t        dec;
    amo_op_e         op_q;
    logic [XLEN-1:0] old_q;
    logic [XLEN-1:0] opnd_q;
    logic [XLEN-1:0] new_w;

    amo_decode dec_i (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    amo_alu alu_i (
        .op_i   (op_q),
        .old_i  (old_q),
        .opnd_i (opnd_q),
        .new_o  (new_w)
    );

    amo_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .dec_i        (dec),
        .rs1_i        (rs1_i),
        .rs2_i        (rs2_i),
        .new_i        (new_w),
        .op_o         (op_q),
        .old_o        (old_q),
        .opnd_o       (opnd_q),
        .busy_o       (busy_o),
        .illegal_o    (illegal_o),
        .misalign_o   (misalign_o),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_be_o     (mem_be_o),
        .mem_ready_i  (mem_ready_i),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .rd_we_o      (rd_we_o),
        .rd_idx_o     (rd_idx_o)
    );

    assign rd_data_o = old_q;
endmodule

// File: rtl/amo_rmw_chk.sv
module amo_rmw_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              illegal_o,
    input logic              misalign_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [31:0]       mem_wdata_o,
    input logic              mem_ready_i,
    input logic              rd_we_o
);
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_req_o);

    // R5
    wb_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        rd_we_o |-> $past(mem_req_o && mem_we_o && mem_ready_i));

    // R5
    ack_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_we_o && mem_ready_i |=> rd_we_o && !busy_o);

    // R8
    aligned_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00);

    // R7
    illegal_idle_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !busy_o && !rd_we_o && !misalign_o);

    // R8
    misalign_idle_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> !busy_o && !rd_we_o);
endmodule

bind amo_rmw_unit amo_rmw_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .illegal_o   (illegal_o),
    .misalign_o  (misalign_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .rd_we_o     (rd_we_o)
);

// File: tb/amo_rmw_unit_tb.sv
module amo_rmw_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs1_i = '0;
    logic [31:0] rs2_i = '0;
    logic        busy_o, illegal_o, misalign_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [3:0]  mem_be_o;
    logic        mem_ready_i = 1'b0;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        rd_we_o;
    logic [4:0]  rd_idx_o;
    logic [31:0] rd_data_o;

    always #2 clk = ~clk;

    amo_rmw_unit dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] mem [16];
    logic        poke_en = 1'b0;
    logic [3:0]  poke_idx = '0;
    logic [31:0] poke_val = '0;
    logic        rd_pend = 1'b0;
    logic [31:0] rd_buf = '0;
    logic [7:0]  lfsr = 8'hA5;
    int          wb_cnt = 0;
    int          wr_cnt = 0;
    int          rq_cnt = 0;
    logic [31:0] rd_addr_seen = '0;
    logic [31:0] wr_addr_seen = '0;
    logic [3:0]  wr_be_seen = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_we_o) wb_cnt <= wb_cnt + 1;
        if (poke_en) mem[poke_idx] <= poke_val;
        if (mem_rvalid_i) rd_pend <= 1'b0;
        if (mem_req_o && mem_ready_i) begin
            rq_cnt <= rq_cnt + 1;
            if (mem_we_o) begin
                mem[mem_addr_o[5:2]] <= mem_wdata_o;
                wr_addr_seen <= mem_addr_o;
                wr_be_seen   <= mem_be_o;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_pend      <= 1'b1;
                rd_buf       <= mem[mem_addr_o[5:2]];
                rd_addr_seen <= mem_addr_o;
            end
        end
    end

    always @(negedge clk) begin
        lfsr         <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready_i  <= lfsr[0] | lfsr[3];
        mem_rvalid_i <= rd_pend && !mem_rvalid_i;
        mem_rdata_i  <= rd_buf;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [4:0] f5, input logic [31:0] a,
                                          input logic [31:0] b);
        int signed sa, sb;
        sa = a; sb = b;
        case (f5)
            5'b00001: return b;
            5'b00000: return a + b;
            5'b01100: return a & b;
            5'b01000: return a | b;
            5'b00100: return a ^ b;
            5'b10000: return (sa < sb) ? a : b;
            5'b10100: return (sa > sb) ? a : b;
            5'b11000: return (a < b) ? a : b;
            5'b11100: return (a > b) ? a : b;
            default:  return a;
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] f5, input logic [1:0] aqrl,
                                       input logic [2:0] w, input logic [4:0] rd,
                                       input logic [6:0] opc);
        return {f5, aqrl, 5'd2, 5'd1, w, rd, opc};
    endfunction

    task automatic poke(input int k, input logic [31:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = 4'(k); poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic do_amo(input logic [4:0] f5, input logic [1:0] aqrl, input int k,
                          input logic [31:0] a, input logic [31:0] b, input logic [4:0] rd,
                          input string req);
        logic [31:0] addr;
        int wb0;
        int rq0;
        bit seen;
        addr = 32'h100 + 32'(k * 4);
        poke(k, a);
        wb0 = wb_cnt;
        rq0 = rq_cnt;
        start_i = 1'b1;
        instr_i = mk(f5, aqrl, 3'b010, rd, 7'b0101111);
        rs1_i = addr; rs2_i = b;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R6", "busy after accept", 32'(busy_o), 1);
        seen = 1'b0;
        for (int t = 0; t < 60 && !seen; t++) begin
            @(negedge clk);
            if (rd_we_o) seen = 1'b1;
        end
        check(seen, "R5", "rd write pulse seen", 32'(seen), 1);
        check(rd_data_o == a, "R5", "rd gets old word", rd_data_o, a);
        check(rd_idx_o == rd, "R5", "rd index", 32'(rd_idx_o), 32'(rd));
        check(mem[k] == model(f5, a, b), req, $sformatf("new word f5=%05b", f5),
              mem[k], model(f5, a, b));
        check(busy_o == 1'b0, "R6", "busy low at rd write", 32'(busy_o), 0);
        check(rd_addr_seen == addr && wr_addr_seen == addr, "R4", "rd/wr address",
              wr_addr_seen, addr);
        check(wr_be_seen == 4'hF, "R4", "byte lanes", 32'(wr_be_seen), 32'hF);
        check(rq_cnt - rq0 == 2, "R4", "two requests", 32'(rq_cnt - rq0), 2);
        @(negedge clk);
        check(wb_cnt - wb0 == 1, "R5", "single rd pulse", 32'(wb_cnt - wb0), 1);
    endtask

    task automatic do_rej(input logic [31:0] ins, input logic [31:0] addr,
                          input bit e_ill, input bit e_mis, input string req);
        int wb0;
        int wr0;
        int rq0;
        poke(3, 32'hCAFE0000 ^ ins);
        wb0 = wb_cnt; wr0 = wr_cnt; rq0 = rq_cnt;
        start_i = 1'b1; instr_i = ins; rs1_i = addr; rs2_i = 32'h1234;
        @(negedge clk);
        start_i = 1'b0;
        check(illegal_o == e_ill, req, "illegal flag", 32'(illegal_o), 32'(e_ill));
        check(misalign_o == e_mis, req, "misalign flag", 32'(misalign_o), 32'(e_mis));
        check(busy_o == 1'b0, req, "busy stays low", 32'(busy_o), 0);
        @(negedge clk);
        check(!illegal_o && !misalign_o, req, "flags one cycle",
              32'({illegal_o, misalign_o}), 0);
        repeat (3) @(negedge clk);
        check(wb_cnt == wb0 && rq_cnt == rq0 && wr_cnt == wr0, req, "no mem or rd",
              32'(rq_cnt - rq0 + wb_cnt - wb0), 0);
        check(mem[3] == (32'hCAFE0000 ^ ins), req, "word untouched", mem[3],
              32'hCAFE0000 ^ ins);
    endtask

    logic [4:0] ops [9] = '{5'b00001, 5'b00000, 5'b01100, 5'b01000, 5'b00100,
                            5'b10000, 5'b10100, 5'b11000, 5'b11100};
    logic [31:0] va [7] = '{32'h0, 32'h5, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF,
                            32'h12345678, 32'hFFFFFFFE};
    logic [31:0] vb [7] = '{32'h0, 32'h3, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                            32'h0F0F00FF, 32'hFFFFFFFF};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !mem_req_o && !rd_we_o && !illegal_o && !misalign_o, "R6",
              "reset state", 32'({busy_o, mem_req_o, rd_we_o}), 0);
        for (int i = 0; i < 9; i++) begin
            for (int j = 0; j < 7; j++) begin
                do_amo(ops[i], 2'(i + j), (i + j) % 16, va[j], vb[j], 5'(1 + i + j),
                       (i >= 5) ? "R3" : "R2");
            end
        end
        for (int q = 0; q < 4; q++)
            do_amo(5'b00000, 2'(q), 7, 32'h10, 32'h22, 5'd9, "R9");
        for (int f = 0; f < 32; f++) begin
            if (f != 0 && f != 1 && f != 4 && f != 8 && f != 12 && f != 16 &&
                f != 20 && f != 24 && f != 28)
                do_rej(mk(5'(f), 2'b00, 3'b010, 5'd4, 7'b0101111), 32'h10C, 1'b1, 1'b0, "R7");
        end
        do_rej(mk(5'b00000, 2'b00, 3'b011, 5'd4, 7'b0101111), 32'h10C, 1'b1, 1'b0, "R7");
        for (int m = 1; m < 4; m++)
            do_rej(mk(5'b00001, 2'b11, 3'b010, 5'd4, 7'b0101111), 32'h10C + 32'(m),
                   1'b0, 1'b1, "R8");
        do_rej(mk(5'b00010, 2'b00, 3'b010, 5'd4, 7'b0101111), 32'h10D, 1'b1, 1'b0, "R8");
        do_rej(mk(5'b00000, 2'b00, 3'b010, 5'd4, 7'b0110011), 32'h10C, 1'b0, 1'b0, "R1");
        do_rej(mk(5'b00001, 2'b00, 3'b010, 5'd4, 7'b0101011), 32'h10C, 1'b0, 1'b0, "R1");
        do_amo(5'b00001, 2'b01, 15, 32'hDEADBEEF, 32'h0BADF00D, 5'd31, "R1");
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 100000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule